// File: doc/BRIEF.md
# PCI Type 0 Configuration Target

This block answers configuration reads and writes on a PCI-style bus for a single-function device. When a configuration cycle arrives with the device's ID-select input high and the two lowest address bits clear (a Type 0 cycle), the block claims it. One clock later it raises device-select and holds it until the single data phase is strobed. It takes the DWORD index from address bits [7:2]. The function-number field and all higher address bits are ignored.

The configuration space covers the first 64 bytes of the standard header. It holds identification, command, status, class code, revision, latency timer, header type, one I/O base address and the interrupt line and pin. Accesses may be 8, 16 or 32 bits wide, selected lane by lane through byte enables in little-endian order. Reserved DWORDs, and any index of 16 or above, are claimed but read zero and ignore writes. A hard reset clears only the Command register. Soft reset, sleep and a busy flag from a non-volatile parameter loader have no effect on the registers and never delay a response.

Top module: `cfg_target`

## Requirements
- R1: A Type 0 configuration cycle (addr_phase, cfg_cycle and idsel high, addr[1:0] = 00) raises devsel on the next clock edge. devsel stays high while data_phase is low and drops on the edge after the clock in which data_phase is high.
- R2: No cycle is claimed, and devsel stays low, when idsel is low, when cfg_cycle is low, or when addr[1:0] is not 00.
- R3: The DWORD index is addr[7:2]. Bits addr[31:8], including the function number in addr[10:8], do not change which register is reached.
- R4: Byte enable be[k] gates lane k (bits 8k+7..8k). A read returns zero in disabled lanes, and a write changes only enabled lanes. rdata is zero whenever no read data phase is active.
- R5: Fixed fields read as follows. DWORD 0 gives {Device ID 16'h3C4D, Vendor ID 16'h1A2B}. DWORD 2 gives {base class 8'h02, sub-class 8'h80, programming interface 8'h00, revision 8'h05}. The upper half of DWORD 1 is the status value 16'h0280. Byte 1 of DWORD 15 is the interrupt pin 8'h01.
- R6: DWORD indices 5 to 14 and every index of 16 or above read all zeros, and writes to them have no effect on any register.
- R7: In the low half of DWORD 1, the Command register accepts only the bits in mask 16'h0147, and its other bits read zero. Hard reset (rst_n low) clears Command.
- R8: The I/O base address in DWORD 4 reads bits [4:0] as 5'b00001, and bits [31:5] keep the value written.
- R9: The latency timer (DWORD 3, byte 1) and the interrupt line (DWORD 15, byte 0) keep any value written. Writes to identification, class, status and interrupt pin fields leave them unchanged.
- R10: Byte 2 of DWORD 3 is the header type, and its bit 23 (the multi-function flag) reads 0. Bytes 0 and 3 of DWORD 3 read zero.
- R11: Hard reset leaves the latency timer, interrupt line and I/O base unchanged. soft_rst, sleep_req and load_busy change no register, and cycles are claimed without delay while any of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset request (no effect on configuration state) |
| sleep_req | input | 1 | Sleep request (no effect on configuration state) |
| load_busy | input | 1 | Non-volatile parameter load in progress (never stalls access) |
| addr_phase | input | 1 | Address phase strobe |
| cfg_cycle | input | 1 | Current cycle is a configuration cycle |
| idsel | input | 1 | ID-select for this device |
| wr | input | 1 | 1 = write, 0 = read, sampled with addr_phase |
| addr | input | 32 | Address phase value |
| data_phase | input | 1 | Data phase strobe |
| be | input | 4 | Byte enables for the data phase, active high |
| wdata | input | 32 | Write data |
| devsel | output | 1 | Device select, cycle claimed |
| rdata | output | 32 | Read data, valid during a read data phase |

## Verification
The assertions assume a well-formed single-beat bus. No new address phase is meant for this block while devsel is high, and idsel, cfg_cycle and wr are only meaningful together with addr_phase. The stimulus follows these rules. Every transaction drives one address phase, then drives a data phase after zero or more idle cycles. The next address phase waits until devsel has dropped. Unclaimed cycles, reserved indices, delayed data phases and the reset and sleep inputs are all exercised under these same rules. Nothing is driven that a bus master could not legally present.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

   localparam int BUS_W  = 32;
   localparam int LANES  = BUS_W / 8;
   localparam int IDX_W  = 6;

   localparam logic [IDX_W-1:0] IDX_IDENT   = 6'd0;
   localparam logic [IDX_W-1:0] IDX_CMDSTAT = 6'd1;
   localparam logic [IDX_W-1:0] IDX_CLASS   = 6'd2;
   localparam logic [IDX_W-1:0] IDX_MISC    = 6'd3;
   localparam logic [IDX_W-1:0] IDX_IOBASE  = 6'd4;
   localparam logic [IDX_W-1:0] IDX_IRQ     = 6'd15;

   typedef struct packed {
      logic             is_wr;
      logic [IDX_W-1:0] idx;
   } cfg_req_t;

endpackage

// File: rtl/cfg_claim.sv
module cfg_claim
   import cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       addr_phase,
   input  logic       cfg_cycle,
   input  logic       idsel,
   input  logic       wr,
   input  logic [7:0] addr_lo,
   input  logic       data_phase,
   output logic       devsel,
   output cfg_req_t   req,
   output logic       wr_fire,
   output logic       rd_active
);

   logic type0_hit;
   assign type0_hit = addr_phase & cfg_cycle & idsel & (addr_lo[1:0] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         devsel <= 1'b0;
         req    <= '0;
      end else if (!devsel) begin
         if (type0_hit) begin
            devsel    <= 1'b1;
            req.is_wr <= wr;
            req.idx   <= addr_lo[7:2];
         end
      end else if (data_phase) begin
         devsel <= 1'b0;
      end
   end

   assign wr_fire   = devsel & data_phase & req.is_wr;
   assign rd_active = devsel & ~req.is_wr;

   p_claim_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel && addr_phase && cfg_cycle && idsel && addr_lo[1:0] == 2'b00)
      |=> (devsel && req.idx == $past(addr_lo[7:2])));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (devsel && !data_phase) |=> devsel);

   p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (devsel && data_phase) |=> !devsel);

   p_noclaim_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!devsel && (!idsel || !cfg_cycle || !addr_phase || addr_lo[1:0] != 2'b00)) |=> !devsel);

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
   import cfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
   parameter logic [7:0]  REV_ID     = 8'h05,
   parameter logic [7:0]  PROG_IF    = 8'h00,
   parameter logic [7:0]  SUB_CLASS  = 8'h80,
   parameter logic [7:0]  BASE_CLASS = 8'h02,
   parameter logic [7:0]  HDR_TYPE   = 8'h80,
   parameter logic [7:0]  INT_PIN    = 8'h01,
   parameter logic [15:0] STATUS_RO  = 16'h0280,
   parameter logic [15:0] CMD_WMASK  = 16'h0147,
   parameter int          IO_SPAN    = 32,
   parameter bit          IO_BAR_EN  = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_fire,
   input  logic [IDX_W-1:0] idx,
   input  logic [LANES-1:0] be,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rd_word
);

   localparam int               IO_LSB    = $clog2(IO_SPAN);
   localparam logic [BUS_W-1:0] BAR_WMASK = ~(BUS_W'(IO_SPAN) - 1);
   localparam logic [BUS_W-1:0] BAR_FIXED = BUS_W'(1);

   logic [15:0]      cmd_q;
   logic [7:0]       lat_q;
   logic [7:0]       irq_line_q;
   logic [BUS_W-1:0] bar_word;

   // Command: the only register with a hard reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (wr_fire && idx == IDX_CMDSTAT) begin
         for (int k = 0; k < 2; k++) begin
            if (be[k]) cmd_q[8*k +: 8] <= wdata[8*k +: 8] & CMD_WMASK[8*k +: 8];
         end
      end
   end

   // Latency timer and interrupt line keep their value across every reset
   always_ff @(posedge clk) begin
      if (wr_fire && idx == IDX_MISC && be[1]) lat_q <= wdata[15:8];
   end

   always_ff @(posedge clk) begin
      if (wr_fire && idx == IDX_IRQ && be[0]) irq_line_q <= wdata[7:0];
   end

   generate
      if (IO_BAR_EN) begin : g_bar
         logic [BUS_W-1:0] bar_q;
         always_ff @(posedge clk) begin
            if (wr_fire && idx == IDX_IOBASE) begin
               for (int k = 0; k < LANES; k++) begin
                  if (be[k]) bar_q[8*k +: 8] <= wdata[8*k +: 8] & BAR_WMASK[8*k +: 8];
               end
            end
         end
         assign bar_word = (bar_q & BAR_WMASK) | BAR_FIXED;
      end else begin : g_nobar
         assign bar_word = '0;
      end
   endgenerate

   always_comb begin
      case (idx)
         IDX_IDENT:   rd_word = {DEVICE_ID, VENDOR_ID};
         IDX_CMDSTAT: rd_word = {STATUS_RO, cmd_q};
         IDX_CLASS:   rd_word = {BASE_CLASS, SUB_CLASS, PROG_IF, REV_ID};
         IDX_MISC:    rd_word = {8'h00, 1'b0, HDR_TYPE[6:0], lat_q, 8'h00};
         IDX_IOBASE:  rd_word = bar_word;
         IDX_IRQ:     rd_word = {16'h0000, INT_PIN, irq_line_q};
         default:     rd_word = '0;
      endcase
   end

   p_cmd_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == IDX_CMDSTAT) |-> ((rd_word[15:0] & ~CMD_WMASK) == 16'h0000));

   p_bar_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (IO_BAR_EN && idx == IDX_IOBASE) |-> (rd_word[IO_LSB-1:0] == BAR_FIXED[IO_LSB-1:0]));

   p_hdr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == IDX_MISC) |-> (rd_word[23] == 1'b0));

   p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idx > IDX_IOBASE && idx != IDX_IRQ) |-> (rd_word == '0));

   p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_fire |=> ($stable(cmd_q) && $stable(lat_q) && $stable(irq_line_q)));

endmodule

// File: rtl/cfg_target.sv
module cfg_target
   import cfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
   parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
   parameter logic [7:0]  REV_ID     = 8'h05,
   parameter logic [7:0]  PROG_IF    = 8'h00,
   parameter logic [7:0]  SUB_CLASS  = 8'h80,
   parameter logic [7:0]  BASE_CLASS = 8'h02,
   parameter logic [7:0]  HDR_TYPE   = 8'h80,
   parameter logic [7:0]  INT_PIN    = 8'h01,
   parameter logic [15:0] STATUS_RO  = 16'h0280,
   parameter logic [15:0] CMD_WMASK  = 16'h0147,
   parameter int          IO_SPAN    = 32,
   parameter bit          IO_BAR_EN  = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        sleep_req,
   input  logic        load_busy,
   input  logic        addr_phase,
   input  logic        cfg_cycle,
   input  logic        idsel,
   input  logic        wr,
   input  logic [31:0] addr,
   input  logic        data_phase,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic        devsel,
   output logic [31:0] rdata
);

   generate
      if (IO_SPAN < 16 || IO_SPAN > 256 || (IO_SPAN & (IO_SPAN - 1)) != 0) begin : g_bad_span
         $error("cfg_target: IO_SPAN must be a power of two from 16 to 256");
      end
      if (BUS_W != 32 || LANES != 4) begin : g_bad_bus
         $error("cfg_target: package bus width must be 32 bits");
      end
   endgenerate

   cfg_req_t         req;
   logic             wr_fire;
   logic             rd_active;
   logic [BUS_W-1:0] rd_word;

   // Upper address bits, function number and power-state inputs are not decoded
   logic unused_inputs;
   assign unused_inputs = ^{addr[31:8], soft_rst, sleep_req};

   cfg_claim u_claim (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_phase (addr_phase),
      .cfg_cycle  (cfg_cycle),
      .idsel      (idsel),
      .wr         (wr),
      .addr_lo    (addr[7:0]),
      .data_phase (data_phase),
      .devsel     (devsel),
      .req        (req),
      .wr_fire    (wr_fire),
      .rd_active  (rd_active)
   );

   cfg_regs #(
      .VENDOR_ID  (VENDOR_ID),
      .DEVICE_ID  (DEVICE_ID),
      .REV_ID     (REV_ID),
      .PROG_IF    (PROG_IF),
      .SUB_CLASS  (SUB_CLASS),
      .BASE_CLASS (BASE_CLASS),
      .HDR_TYPE   (HDR_TYPE),
      .INT_PIN    (INT_PIN),
      .STATUS_RO  (STATUS_RO),
      .CMD_WMASK  (CMD_WMASK),
      .IO_SPAN    (IO_SPAN),
      .IO_BAR_EN  (IO_BAR_EN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .idx     (req.idx),
      .be      (be),
      .wdata   (wdata),
      .rd_word (rd_word)
   );

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         assign rdata[8*gl +: 8] = (rd_active && be[gl]) ? rd_word[8*gl +: 8] : 8'h00;
      end
   endgenerate

   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !devsel |-> (rdata == 32'h0));

   p_lane_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (be == 4'h0) |-> (rdata == 32'h0));

   p_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load_busy && !devsel && addr_phase && cfg_cycle && idsel && addr[1:0] == 2'b00) |=> devsel);

endmodule

// File: tb/cfg_target_tb.sv
module cfg_target_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, sleep_req = 1'b0, load_busy = 1'b0;
   logic        addr_phase = 1'b0, cfg_cycle = 1'b0, idsel = 1'b0, wr = 1'b0;
   logic [31:0] addr = '0;
   logic        data_phase = 1'b0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic        devsel;
   logic [31:0] rdata;

   always #4 clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string cur_req = "R1";

   cfg_target u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep_req(sleep_req),
      .load_busy(load_busy), .addr_phase(addr_phase), .cfg_cycle(cfg_cycle),
      .idsel(idsel), .wr(wr), .addr(addr), .data_phase(data_phase), .be(be),
      .wdata(wdata), .devsel(devsel), .rdata(rdata)
   );

   // ---------------- behavioural reference model ----------------
   bit          m_busy = 1'b0;
   bit          m_wr   = 1'b0;
   int          m_idx  = 0;
   logic [15:0] m_cmd  = '0;
   logic [7:0]  m_lat  = '0;
   logic [7:0]  m_irq  = '0;
   logic [31:0] m_bar  = '0;
   bit          k_lat = 1'b0, k_irq = 1'b0, k_bar = 1'b0;

   function automatic logic [31:0] m_read(int idx);
      case (idx)
         0:       return 32'h3C4D1A2B;
         1:       return {16'h0280, m_cmd};
         2:       return 32'h02800005;
         3:       return {16'h0000, m_lat, 8'h00};
         4:       return {m_bar[31:5], 5'b00001};
         15:      return {16'h0000, 8'h01, m_irq};
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit m_known(int idx);
      if (idx == 3)  return k_lat;
      if (idx == 4)  return k_bar;
      if (idx == 15) return k_irq;
      return 1'b1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy <= 1'b0;
         m_cmd  <= '0;
      end else if (!m_busy) begin
         if (addr_phase && cfg_cycle && idsel && addr[1:0] == 2'b00) begin
            m_busy <= 1'b1;
            m_wr   <= wr;
            m_idx  <= int'(addr[7:2]);
         end
      end else if (data_phase) begin
         m_busy <= 1'b0;
         if (m_wr) begin
            case (m_idx)
               1: begin
                  if (be[0]) m_cmd[7:0]  <= wdata[7:0]  & 8'h47;
                  if (be[1]) m_cmd[15:8] <= wdata[15:8] & 8'h01;
               end
               3: if (be[1]) begin m_lat <= wdata[15:8]; k_lat <= 1'b1; end
               4: begin
                  for (int k = 0; k < 4; k++) if (be[k]) m_bar[8*k +: 8] <= wdata[8*k +: 8];
                  if (be == 4'hF) k_bar <= 1'b1;
               end
               15: if (be[0]) begin m_irq <= wdata[7:0]; k_irq <= 1'b1; end
               default: ;
            endcase
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(posedge clk) begin
      logic [31:0] exp_rd;
      bit          rd_chk;
      #3;
      if (!done) begin
         exp_rd = 32'h0;
         rd_chk = 1'b1;
         if (m_busy && !m_wr) begin
            if (!m_known(m_idx)) rd_chk = 1'b0;
            for (int k = 0; k < 4; k++)
               if (be[k]) exp_rd[8*k +: 8] = m_read(m_idx) >> (8*k);
         end
         n_tests++;
         if (devsel !== m_busy || (rd_chk && rdata !== exp_rd)) begin
            n_fail++;
            $display("FAIL %s (per-clock): devsel=%0b rdata=%h, expected devsel=%0b rdata=%h",
                     cur_req, devsel, rdata, m_busy, exp_rd);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic txn(input bit w, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] d, input bit sel, input bit cfg, input int gap,
                      output logic [31:0] rd, output logic dv);
      @(negedge clk);
      addr_phase = 1'b1; addr = a; idsel = sel; cfg_cycle = cfg; wr = w;
      @(negedge clk);
      addr_phase = 1'b0; addr = '0; idsel = 1'b0; cfg_cycle = 1'b0; wr = 1'b0;
      repeat (gap) @(negedge clk);
      data_phase = 1'b1; be = b; wdata = d;
      #1;
      rd = rdata;
      dv = devsel;
      @(negedge clk);
      data_phase = 1'b0; be = '0; wdata = '0;
   endtask

   task automatic cfg_wr(input logic [31:0] a, input logic [3:0] b, input logic [31:0] d);
      logic [31:0] rd;
      logic        dv;
      txn(1'b1, a, b, d, 1'b1, 1'b1, 0, rd, dv);
   endtask

   task automatic cfg_rd(input logic [31:0] a, input logic [3:0] b, output logic [31:0] rd);
      logic dv;
      txn(1'b0, a, b, 32'h0, 1'b1, 1'b1, 0, rd, dv);
   endtask

   initial begin
      logic [31:0] rd;
      logic        dv;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      cur_req = "R1";
      chk("R1 reset devsel", {31'h0, devsel}, 32'h0);
      chk("R4 reset rdata", rdata, 32'h0);

      // establish the registers that have no reset
      cur_req = "R8";
      cfg_wr(32'h10, 4'hF, 32'hFFFF_FFFF);
      cur_req = "R9";
      cfg_wr(32'h0C, 4'h2, 32'h0000_AB00);
      cfg_wr(32'h3C, 4'h1, 32'h0000_0033);

      cur_req = "R5";
      cfg_rd(32'h00, 4'hF, rd);  chk("R5 ident", rd, 32'h3C4D_1A2B);
      cfg_rd(32'h08, 4'hF, rd);  chk("R5 class", rd, 32'h0280_0005);
      cur_req = "R4";
      cfg_rd(32'h08, 4'h4, rd);  chk("R4 single lane sub-class", rd, 32'h0080_0000);
      cfg_rd(32'h00, 4'h6, rd);  chk("R4 middle lanes", rd, 32'h004D_1A00);

      cur_req = "R7";
      cfg_rd(32'h04, 4'hF, rd);  chk("R7 command after reset", rd, 32'h0280_0000);
      cfg_wr(32'h04, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(32'h04, 4'hF, rd);  chk("R7 command mask", rd, 32'h0280_0147);

      cur_req = "R10";
      cfg_rd(32'h0C, 4'hF, rd);  chk("R10 header single-function", rd, 32'h0000_AB00);
      cur_req = "R8";
      cfg_rd(32'h10, 4'hF, rd);  chk("R8 io base low bits", rd, 32'hFFFF_FFE1);
      cur_req = "R4";
      cfg_wr(32'h10, 4'h2, 32'h0000_0000);
      cfg_rd(32'h10, 4'hF, rd);  chk("R4 partial write io base", rd, 32'hFFFF_00E1);

      cur_req = "R6";
      cfg_wr(32'h14, 4'hF, 32'hFFFF_FFFF);
      cfg_rd(32'h14, 4'hF, rd);  chk("R6 reserved dword", rd, 32'h0);
      cfg_rd(32'h50, 4'hF, rd);  chk("R6 index 20", rd, 32'h0);
      cfg_wr(32'h4C, 4'h2, 32'h0000_5500);
      cfg_rd(32'h0C, 4'hF, rd);  chk("R6 index 19 no alias", rd, 32'h0000_AB00);

      cur_req = "R3";
      cfg_rd(32'h0000_0700, 4'hF, rd); chk("R3 function bits ignored", rd, 32'h3C4D_1A2B);
      cfg_wr(32'hFFFF_FF3C, 4'h1, 32'h0000_005A);
      cfg_rd(32'h3C, 4'hF, rd);  chk("R3 upper bits ignored", rd, 32'h0000_015A);

      cur_req = "R9";
      cfg_wr(32'h00, 4'hF, 32'h0);
      cfg_wr(32'h3C, 4'h2, 32'h0000_FF00);
      cfg_rd(32'h00, 4'hF, rd);  chk("R9 ident read-only", rd, 32'h3C4D_1A2B);
      cfg_rd(32'h3C, 4'hF, rd);  chk("R9 pin read-only", rd, 32'h0000_015A);

      cur_req = "R2";
      txn(1'b0, 32'h00, 4'hF, 32'h0, 1'b0, 1'b1, 0, rd, dv);
      chk("R2 idsel low", {31'h0, dv}, 32'h0);
      txn(1'b0, 32'h01, 4'hF, 32'h0, 1'b1, 1'b1, 0, rd, dv);
      chk("R2 type 1 encoding", {31'h0, dv}, 32'h0);
      txn(1'b0, 32'h00, 4'hF, 32'h0, 1'b1, 1'b0, 0, rd, dv);
      chk("R2 not config", {31'h0, dv}, 32'h0);

      cur_req = "R1";
      txn(1'b0, 32'h08, 4'hF, 32'h0, 1'b1, 1'b1, 2, rd, dv);
      chk("R1 devsel held", {31'h0, dv}, 32'h1);
      chk("R1 delayed data", rd, 32'h0280_0005);
      @(negedge clk); #1;
      chk("R1 devsel released", {31'h0, devsel}, 32'h0);

      cur_req = "R11";
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      cfg_rd(32'h04, 4'hF, rd);  chk("R7 hard reset clears command", rd, 32'h0280_0000);
      cfg_rd(32'h0C, 4'hF, rd);  chk("R11 latency survives hard reset", rd, 32'h0000_AB00);
      cfg_rd(32'h10, 4'hF, rd);  chk("R11 io base survives hard reset", rd, 32'hFFFF_00E1);

      cfg_wr(32'h04, 4'h3, 32'h0000_0145);
      soft_rst = 1'b1; sleep_req = 1'b1;
      repeat (4) @(negedge clk);
      cfg_rd(32'h04, 4'hF, rd);  chk("R11 soft reset and sleep keep command", rd, 32'h0280_0145);
      cfg_rd(32'h3C, 4'hF, rd);  chk("R11 soft reset keeps irq line", rd, 32'h0000_015A);
      soft_rst = 1'b0; sleep_req = 1'b0;
      load_busy = 1'b1;
      txn(1'b0, 32'h00, 4'hF, 32'h0, 1'b1, 1'b1, 0, rd, dv);
      chk("R11 no stall on load busy", {31'h0, dv}, 32'h1);
      chk("R11 data during load busy", rd, 32'h3C4D_1A2B);
      load_busy = 1'b0;

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule